// File: doc/BRIEF.md
# Embedded-Sync Video Timing Decoder

This block takes an 8-bit multiplexed 4:2:2 component video stream, one byte per clock, and rebuilds line and field timing from the timing reference words carried inside the stream. No sync pins are used. A timing word is four bytes: 0xFF, 0x00, 0x00 and a status byte. One timing word closes the active part of each line and a second one opens it. The status byte gives the field, vertical-blanking and horizontal-blanking state. The block checks the status byte's protection bits, keeps the last good H, V and F values, and marks the active samples of picture lines with a valid strobe and a sample-phase code.

Each byte comes out again on `dout` one clock after it arrives, whatever it is. Blanking fill and ancillary packets therefore reach downstream logic unchanged, and the valid strobe picks out the picture samples. A lock indicator reports whether the spacing between successive end-of-active words matches the total line length of the selected standard.

Top module: `vid_sync_decoder`

## Requirements
- R1: While `rst_n` is low, and until the first timing word has been accepted, `dvalid`, `phase`, `h_flag`, `v_flag`, `f_flag`, `prot_err` and `locked` are all 0.
- R2: A timing word is the byte sequence 0xFF, 0x00, 0x00 followed by a status byte whose bit 7 is 1. In the status byte, bit 6 is F, bit 5 is V, and bit 4 is H (1 = end-of-active word, 0 = start-of-active word). On the clock after a status byte with correct protection bits arrives, `f_flag`, `v_flag` and `h_flag` show its F, V and H values.
- R3: The protection bits in the status byte are bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H. If they do not match, `prot_err` is high for exactly the following clock, the flags keep their previous values, and no active window opens.
- R4: If the 0xFF, 0x00, 0x00 sequence is followed by a byte with bit 7 at 0, that byte is not a timing word. The flags do not change and `prot_err` stays low.
- R5: After an accepted start-of-active word with V = 0, the next `ACT_SAMPLES` bytes are each reported with `dvalid` high, one clock after they arrive. `dvalid` is low for every other byte, including the samples after a start-of-active word with V = 1.
- R6: `phase` counts the valid samples of a line as 0 (Cb), 1 (Y), 2 (Cr), 3 (Y), and so on. The first sample after each start-of-active word has phase 0. When `dvalid` is low, `phase` is 0.
- R7: `dout` equals the input byte of the previous clock for every byte, including timing words, blanking fill and ancillary data.
- R8: The expected line length is `ACT_SAMPLES + BLANK_525 + 8` clocks when `std_sel` is 0 and `ACT_SAMPLES + BLANK_625 + 8` when `std_sel` is 1. With the default parameters these are 1716 and 1728.
- R9: `locked` rises on the clock after an accepted end-of-active word that completes the second consecutive end-to-end spacing equal to the line length. An accepted end-of-active word at any other spacing clears it. It also clears when no accepted end-of-active word arrives within one line length of the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_sel | input | 1 | Line standard: 0 = 525-line, 1 = 625-line |
| din | input | 8 | Multiplexed 4:2:2 byte stream |
| dout | output | 8 | Input stream delayed by one clock |
| dvalid | output | 1 | High for active picture samples |
| phase | output | 2 | Sample phase: 0 Cb, 1 Y, 2 Cr, 3 Y |
| h_flag | output | 1 | Last accepted H bit |
| v_flag | output | 1 | Last accepted V bit |
| f_flag | output | 1 | Last accepted F bit |
| prot_err | output | 1 | One-clock pulse on a status byte with bad protection bits |
| locked | output | 1 | Line spacing matches the selected standard |

## Verification
The bench builds the decoder with its default parameters: 1440 active samples, blanking of 268 and 280 clocks, and protection checking enabled. Because of this, the lock checks use full-length 1716-clock and 1728-clock lines. A run of 525-line lines followed by 625-line lines tests both targets, including the mismatch at the switch. The blanking gaps are long enough to carry injected ancillary bytes, a fake timing word with bad protection bits, and a preamble followed by a byte that is not a status byte. The 1440-sample windows take the phase counter through many full Cb/Y/Cr/Y cycles.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

   localparam int BYTE_W  = 8;
   localparam int MARK_LEN = 4;

   typedef struct packed {
      logic f;
      logic v;
      logic h;
   } vsd_tmg_t;

   function automatic vsd_tmg_t vsd_fields(input logic [BYTE_W-1:0] xy);
      vsd_tmg_t t;
      t.f = xy[6];
      t.v = xy[5];
      t.h = xy[4];
      return t;
   endfunction

   function automatic logic vsd_prot_ok(input logic [BYTE_W-1:0] xy);
      logic f, v, h;
      f = xy[6];
      v = xy[5];
      h = xy[4];
      return (xy[3] == (v ^ h)) && (xy[2] == (f ^ h)) &&
             (xy[1] == (f ^ v)) && (xy[0] == (f ^ v ^ h));
   endfunction

endpackage

// File: rtl/vsd_marker_det.sv
module vsd_marker_det
   import vsd_pkg::*;
#(
   parameter bit CHECK_PROT = 1'b1,
   parameter int PRE_LEN    = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] din,
   output logic              mk_hit,
   output logic              mk_ok,
   output vsd_tmg_t          mk_tmg
);

   if (PRE_LEN < 2) begin : g_bad_pre
      $error("vsd_marker_det: PRE_LEN must be at least 2");
   end

   // hist[0] holds the newest byte, hist[PRE_LEN-1] the oldest
   logic [BYTE_W-1:0] hist [PRE_LEN];
   logic [PRE_LEN-1:0] pre_match;
   logic               prot_good;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PRE_LEN; i++) hist[i] <= '0;
      end else begin
         hist[0] <= din;
         for (int i = 1; i < PRE_LEN; i++) hist[i] <= hist[i-1];
      end
   end

   for (genvar g = 0; g < PRE_LEN; g++) begin : g_pre
      if (g == PRE_LEN - 1) begin : g_lead
         assign pre_match[g] = (hist[g] == {BYTE_W{1'b1}});
      end else begin : g_zero
         assign pre_match[g] = (hist[g] == '0);
      end
   end

   if (CHECK_PROT) begin : g_prot_chk
      assign prot_good = vsd_prot_ok(din);
   end else begin : g_prot_skip
      assign prot_good = 1'b1;
   end

   assign mk_hit = (&pre_match) & din[BYTE_W-1];
   assign mk_ok  = prot_good;
   assign mk_tmg = vsd_fields(din);

endmodule

// File: rtl/vsd_active_win.sv
module vsd_active_win
   import vsd_pkg::*;
#(
   parameter int ACT_SAMPLES = 1440,
   localparam int ACT_W = $clog2(ACT_SAMPLES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] din,
   input  logic              open_win,
   input  logic              close_win,
   output logic [BYTE_W-1:0] dout,
   output logic              dvalid,
   output logic [1:0]        phase
);

   logic             in_act;
   logic [ACT_W-1:0] act_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout    <= '0;
         dvalid  <= 1'b0;
         phase   <= 2'd0;
         in_act  <= 1'b0;
         act_cnt <= '0;
      end else begin
         dout <= din;
         if (open_win || close_win) begin
            in_act  <= open_win;
            act_cnt <= '0;
            dvalid  <= 1'b0;
            phase   <= 2'd0;
         end else if (in_act) begin
            dvalid  <= 1'b1;
            phase   <= act_cnt[1:0];
            act_cnt <= act_cnt + 1'b1;
            if (act_cnt == ACT_W'(ACT_SAMPLES - 1)) in_act <= 1'b0;
         end else begin
            dvalid <= 1'b0;
            phase  <= 2'd0;
         end
      end
   end

   // R6: consecutive valid samples step the phase by one
   a_r6_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && $past(dvalid)) |-> (phase == $past(phase) + 2'd1));

   // R6: a window always begins on chroma blue
   a_r6_first_cb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dvalid) |-> (phase == 2'd0));

   // R6: phase rests at zero outside the window
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dvalid |-> (phase == 2'd0));

endmodule

// File: rtl/vsd_lock_mon.sv
module vsd_lock_mon #(
   parameter int LINE_A = 1716,
   parameter int LINE_B = 1728,
   localparam int LINE_MAX = (LINE_A > LINE_B) ? LINE_A : LINE_B,
   localparam int CNT_W    = $clog2(LINE_MAX + 1) + 1
)(
   input  logic clk,
   input  logic rst_n,
   input  logic std_sel,
   input  logic eav_hit,
   output logic locked
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] gap_cnt;
   logic [CNT_W-1:0] tgt_last;
   logic             seen;
   logic [1:0]       good;

   assign tgt_last = std_sel ? CNT_W'(LINE_B - 1) : CNT_W'(LINE_A - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_cnt <= '0;
         seen    <= 1'b0;
         good    <= 2'd0;
      end else if (eav_hit) begin
         gap_cnt <= '0;
         seen    <= 1'b1;
         if (seen && gap_cnt == tgt_last)
            good <= (good == 2'd2) ? 2'd2 : good + 2'd1;
         else
            good <= 2'd0;
      end else begin
         if (gap_cnt != CNT_MAX) gap_cnt <= gap_cnt + 1'b1;
         if (seen && gap_cnt >= tgt_last) good <= 2'd0;
      end
   end

   assign locked = (good == 2'd2);

   // R9: lock can only be gained on an accepted end-of-active word
   a_r9_lock_on_eav: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(eav_hit));

endmodule

// File: rtl/vid_sync_decoder.sv
module vid_sync_decoder
   import vsd_pkg::*;
#(
   parameter int ACT_SAMPLES = 1440,
   parameter int BLANK_525   = 268,
   parameter int BLANK_625   = 280,
   parameter bit CHECK_PROT  = 1'b1,
   localparam int LINE_525 = ACT_SAMPLES + BLANK_525 + 2 * MARK_LEN,
   localparam int LINE_625 = ACT_SAMPLES + BLANK_625 + 2 * MARK_LEN
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       std_sel,
   input  logic [7:0] din,
   output logic [7:0] dout,
   output logic       dvalid,
   output logic [1:0] phase,
   output logic       h_flag,
   output logic       v_flag,
   output logic       f_flag,
   output logic       prot_err,
   output logic       locked
);

   if ((ACT_SAMPLES % 4) != 0 || ACT_SAMPLES < 4) begin : g_bad_act
      $error("vid_sync_decoder: ACT_SAMPLES must be a positive multiple of 4");
   end
   if (BLANK_525 < MARK_LEN || BLANK_625 < MARK_LEN) begin : g_bad_blank
      $error("vid_sync_decoder: blanking must cover at least one word");
   end

   logic     mk_hit, mk_ok;
   vsd_tmg_t mk_tmg;
   logic     mk_accept, sav_ok, eav_ok;

   vsd_marker_det #(.CHECK_PROT(CHECK_PROT), .PRE_LEN(MARK_LEN - 1)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (din),
      .mk_hit (mk_hit),
      .mk_ok  (mk_ok),
      .mk_tmg (mk_tmg)
   );

   assign mk_accept = mk_hit & mk_ok;
   assign sav_ok    = mk_accept & ~mk_tmg.h;
   assign eav_ok    = mk_accept &  mk_tmg.h;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_flag   <= 1'b0;
         v_flag   <= 1'b0;
         h_flag   <= 1'b0;
         prot_err <= 1'b0;
      end else begin
         prot_err <= mk_hit & ~mk_ok;
         if (mk_accept) begin
            f_flag <= mk_tmg.f;
            v_flag <= mk_tmg.v;
            h_flag <= mk_tmg.h;
         end
      end
   end

   vsd_active_win #(.ACT_SAMPLES(ACT_SAMPLES)) u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (din),
      .open_win  (sav_ok & ~mk_tmg.v),
      .close_win (mk_accept),
      .dout      (dout),
      .dvalid    (dvalid),
      .phase     (phase)
   );

   vsd_lock_mon #(.LINE_A(LINE_525), .LINE_B(LINE_625)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .std_sel (std_sel),
      .eav_hit (eav_ok),
      .locked  (locked)
   );

   // R3: a rejected status byte leaves the stored flags untouched
   a_r3_err_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
      prot_err |-> $stable({f_flag, v_flag, h_flag}));

   // R5: valid samples occur only between a picture-line start word and the next word
   a_r5_dv_in_picture: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid |-> (!v_flag && !h_flag));

   // R3: an error pulse lasts a single clock
   a_r3_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      prot_err |=> (!prot_err || $past(mk_hit)));

endmodule

// File: tb/sim_vid_sync_decoder.sv
module sim_vid_sync_decoder;

   localparam int ACT = 1440;
   localparam int BLK [2] = '{268, 280};

   logic       clk = 1'b0;
   logic       rst_n;
   logic       std_sel;
   logic [7:0] din;
   logic [7:0] dout;
   logic       dvalid;
   logic [1:0] phase;
   logic       h_flag, v_flag, f_flag, prot_err, locked;

   always #5 clk = ~clk;

   vid_sync_decoder u0 (
      .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .din(din),
      .dout(dout), .dvalid(dvalid), .phase(phase),
      .h_flag(h_flag), .v_flag(v_flag), .f_flag(f_flag),
      .prot_err(prot_err), .locked(locked)
   );

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit  ef = 1'b0, ev = 1'b0, eh = 1'b0;
   int  sent = 0;
   int  last_eav = -1;
   int  egood = 0;

   function automatic logic [7:0] mkxy(bit f, bit v, bit h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   function automatic int line_len(bit s);
      return ACT + BLK[s] + 8;
   endfunction

   function automatic logic [7:0] rnd_byte();
      return 8'(1 + $urandom_range(253));
   endfunction

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // drive one byte, let the design register it, compare at the falling edge
   task automatic put(logic [7:0] b, bit edv, int eph, bit eerr);
      din = b;
      @(negedge clk);
      sent++;
      chk("R7 dout", dout, b);
      chk("R5 dvalid", dvalid, edv);
      chk("R6 phase", phase, eph);
      chk("R3 prot_err", prot_err, eerr);
      chk("R2 f_flag", f_flag, ef);
      chk("R2 v_flag", v_flag, ev);
      chk("R2 h_flag", h_flag, eh);
   endtask

   task automatic send_mark(bit f, bit v, bit h, bit bad);
      int idx;
      put(8'hFF, 0, 0, 0);
      put(8'h00, 0, 0, 0);
      put(8'h00, 0, 0, 0);
      idx = sent;
      if (!bad) begin
         ef = f; ev = v; eh = h;
         if (h) begin
            if (last_eav >= 0 && idx - last_eav == line_len(std_sel))
               egood = (egood >= 2) ? 2 : egood + 1;
            else
               egood = 0;
            last_eav = idx;
         end
      end
      put(mkxy(f, v, h) ^ {7'd0, bad}, 0, 0, bad);
      if (h && !bad) chk("R9 locked", locked, (egood == 2) ? 1 : 0);
   endtask

   task automatic send_line(bit s, bit f, bit v, bit anc, bit bad_sav, bit bad_eav);
      bit dv;
      std_sel = s;
      send_mark(f, v, 1'b1, bad_eav);
      for (int i = 0; i < BLK[s] - 8; ) begin
         if (anc && i == 20) begin
            // fake word with broken protection: R3
            put(8'hFF, 0, 0, 0); put(8'h00, 0, 0, 0); put(8'h00, 0, 0, 0);
            put(mkxy(~f, v, 1'b0) ^ 8'h01, 0, 0, 1);
            i += 4;
         end else if (anc && i == 30) begin
            // preamble followed by a non-status byte: R4
            put(8'hFF, 0, 0, 0); put(8'h00, 0, 0, 0); put(8'h00, 0, 0, 0);
            put(8'h12, 0, 0, 0);
            chk("R4 prot_err", prot_err, 0);
            chk("R4 flags", {f_flag, v_flag, h_flag}, {ef, ev, eh});
            i += 4;
         end else if (anc && i >= 40 && i < 60) begin
            put(rnd_byte(), 0, 0, 0);
            i++;
         end else begin
            put((i % 2 == 0) ? 8'h80 : 8'h10, 0, 0, 0);
            i++;
         end
      end
      // pad the remainder so the line length is exact
      for (int i = 0; i < 8; i++) put((i % 2 == 0) ? 8'h80 : 8'h10, 0, 0, 0);
      send_mark(f, v, 1'b0, bad_sav);
      dv = !bad_sav && !v;
      for (int i = 0; i < ACT; i++) begin
         if (dv) put(rnd_byte(), 1, i % 4, 0);
         else    put((i % 2 == 0) ? 8'h80 : 8'h10, 0, 0, 0);
      end
   endtask

   initial begin
      void'($urandom(32'h00C0FFEE));
      rst_n   = 1'b0;
      std_sel = 1'b0;
      din     = 8'h00;
      repeat (3) @(negedge clk);
      chk("R1 dvalid", dvalid, 0);
      chk("R1 phase", phase, 0);
      chk("R1 flags", {f_flag, v_flag, h_flag}, 0);
      chk("R1 prot_err", prot_err, 0);
      chk("R1 locked", locked, 0);
      rst_n = 1'b1;
      put(8'h10, 0, 0, 0);
      chk("R1 locked after release", locked, 0);

      // 525-line standard: vertical blanking lines, then picture lines
      send_line(0, 0, 1, 0, 0, 0);
      send_line(0, 0, 1, 0, 0, 0);
      send_line(0, 0, 1, 1, 0, 0);
      chk("R9 locked after three lines", locked, 1);
      send_line(0, 0, 0, 1, 0, 0);
      send_line(0, 0, 0, 0, 0, 0);
      send_line(0, 0, 0, 0, 1, 0);   // corrupted start word: no window
      send_line(0, 0, 0, 0, 0, 1);   // corrupted end word: spacing broken
      send_line(0, 0, 0, 0, 0, 0);
      chk("R9 lock lost on skipped end word", locked, 0);

      // 625-line standard, second field
      send_line(1, 1, 0, 0, 0, 0);
      chk("R8 625 target rejects 525 spacing", locked, 0);
      send_line(1, 1, 0, 1, 0, 0);
      send_line(1, 1, 0, 0, 0, 0);
      chk("R8 625 line length locks", locked, 1);

      // stream with no timing words: lock must time out
      for (int i = 0; i < 2000; i++) put((i % 2 == 0) ? 8'h80 : 8'h10, 0, 0, 0);
      chk("R9 lock timeout", locked, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule